// File: doc/BRIEF.md
# System Exception Pending Control Register Logic

This block is the register-facing front end for the pending state of the core system exceptions. It packs a live status word from the processor's exception state: the vector currently being serviced, the highest vector waiting for service, whether any external interrupt is waiting, and whether some external interrupt other than the current one is still in service. It also reports the pending state of the non-maskable, deferred-service and periodic-tick exceptions. Writes to the same word request that these exceptions be set pending, or that the deferred-service and tick exceptions be cleared. The block holds no pending state itself. It issues one-cycle set and clear strobes that the priority logic elsewhere in the controller acts on.

A second write-only register lets software raise any external interrupt by number. The number is checked against the configured interrupt count, and an out-of-range request produces no strobe. A read-only type register reports how many banks of 32 external interrupts exist. External interrupts carry vector numbers from 16 upward, with the system exceptions below them. Interrupt index i is therefore vector i+16.

Top module: `icsr_ctrl`

## Requirements
- R1: After reset every strobe output is low and the read data output is zero.
- R2: In the status word at offset 0xD04, bits [8:0] hold the active vector number when the active-valid input is high, and zero otherwise. Bits [20:12] hold the pending vector number when the pending-valid input is high, and zero otherwise.
- R3: Status bit 22 reads one exactly when at least one bit of the external pending vector is set.
- R4: Status bit 11 reads one exactly when some external interrupt i is active whose vector i+16 is not the active vector. When no vector is active, every active external interrupt counts.
- R5: Status bits 31, 28 and 26 read the NMI, deferred-service and tick pending inputs. Bits 9, 10, 21, 23, 24, 25, 27, 29 and 30 read zero.
- R6: Writing a word to 0xD04 with bit 31, 28 or 26 set raises the NMI-set, deferred-service-set or tick-set strobe respectively, in the cycle after the write.
- R7: In a write to 0xD04, bit 27 raises the deferred-service clear strobe only when bit 28 is zero. Bit 25 raises the tick clear strobe only when bit 26 is zero. A set and a clear of the same exception never issue together.
- R8: Writing to offset 0xF00 takes bits [8:0] as an external interrupt index. When the index is below NUM_IRQ, the trigger strobe and that index appear in the cycle after the write. Otherwise no strobe is issued.
- R9: A read of offset 0x004 returns NUM_IRQ/32 - 1. A read of any offset other than 0x004 and 0xD04 returns zero.
- R10: Read data appears in the cycle after a read request and holds its value until the next read request.
- R11: Each strobe lasts one cycle. Writes to any other offset, or no write at all, raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write request |
| rd_en_i | input | 1 | Register read request |
| addr_i | input | 12 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| act_valid_i | input | 1 | A vector is in service |
| act_vec_i | input | 9 | Vector number in service |
| pend_valid_i | input | 1 | A vector is waiting |
| pend_vec_i | input | 9 | Highest waiting vector number |
| irq_pend_i | input | NUM_IRQ | Per-interrupt pending state |
| irq_act_i | input | NUM_IRQ | Per-interrupt active state |
| nmi_pend_i | input | 1 | NMI pending state |
| dsrv_pend_i | input | 1 | Deferred-service pending state |
| tick_pend_i | input | 1 | Tick pending state |
| nmi_set_o | output | 1 | Request NMI pending |
| dsrv_set_o | output | 1 | Request deferred-service pending |
| dsrv_clr_o | output | 1 | Clear deferred-service pending |
| tick_set_o | output | 1 | Request tick pending |
| tick_clr_o | output | 1 | Clear tick pending |
| ext_trig_o | output | 1 | Raise an external interrupt |
| ext_trig_id_o | output | 9 | Index of the raised external interrupt |

## Verification
The set and clear requests for one exception can arrive in the same write word, so a single bus cycle can ask for both. The bench writes words with bits 28 and 27 set together, and bits 26 and 25 set together. It also writes mixed words, such as a tick set alongside a deferred-service clear. It judges these writes by the full strobe vector in the following cycle: the set strobe must be high and the opposing clear strobe low, while an unopposed clear in the same word still fires.

// File: rtl/icsr_pkg.sv
package icsr_pkg;

    localparam int VEC_W  = 9;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_TYPE = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_STAT = 12'hD04;
    localparam logic [ADDR_W-1:0] OFS_TRIG = 12'hF00;

    // bit positions of the status / control word
    localparam int B_PEND_LO  = 12;
    localparam int B_OTHERACT = 11;
    localparam int B_ANYPEND  = 22;
    localparam int B_NMI_SET  = 31;
    localparam int B_DSRV_SET = 28;
    localparam int B_DSRV_CLR = 27;
    localparam int B_TICK_SET = 26;
    localparam int B_TICK_CLR = 25;

    localparam int EXT_VEC_BASE = 16;

    typedef struct packed {
        logic nmi_set;
        logic dsrv_set;
        logic dsrv_clr;
        logic tick_set;
        logic tick_clr;
    } sys_strb_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        sys_strb_t         sys;
        logic              trig;
        logic [VEC_W-1:0]  trig_id;
    } regs_t;

endpackage

// File: rtl/icsr_status.sv
module icsr_status
    import icsr_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic               act_valid_i,
    input  logic [VEC_W-1:0]   act_vec_i,
    input  logic               pend_valid_i,
    input  logic [VEC_W-1:0]   pend_vec_i,
    input  logic [NUM_IRQ-1:0] irq_pend_i,
    input  logic [NUM_IRQ-1:0] irq_act_i,
    input  logic               nmi_pend_i,
    input  logic               dsrv_pend_i,
    input  logic               tick_pend_i,
    output logic [DATA_W-1:0]  word_o
);

    logic [NUM_IRQ-1:0] other_act;

    // one comparator per external line: active and not the one in service
    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_other
        localparam logic [VEC_W-1:0] MY_VEC = VEC_W'(gi + EXT_VEC_BASE);
        assign other_act[gi] = irq_act_i[gi] && (!act_valid_i || (act_vec_i != MY_VEC));
    end

    always_comb begin
        word_o = '0;
        if (act_valid_i) begin
            word_o[VEC_W-1:0] = act_vec_i;
        end
        if (pend_valid_i) begin
            word_o[B_PEND_LO +: VEC_W] = pend_vec_i;
        end
        word_o[B_OTHERACT] = |other_act;
        word_o[B_ANYPEND]  = |irq_pend_i;
        word_o[B_NMI_SET]  = nmi_pend_i;
        word_o[B_DSRV_SET] = dsrv_pend_i;
        word_o[B_TICK_SET] = tick_pend_i;
    end

endmodule

// File: rtl/icsr_wr_decode.sv
module icsr_wr_decode
    import icsr_pkg::*;
(
    input  logic      hit_i,
    input  logic      nmi_bit_i,
    input  logic      dsrv_set_bit_i,
    input  logic      dsrv_clr_bit_i,
    input  logic      tick_set_bit_i,
    input  logic      tick_clr_bit_i,
    output sys_strb_t strb_o
);

    always_comb begin
        strb_o          = '0;
        strb_o.nmi_set  = hit_i && nmi_bit_i;
        strb_o.dsrv_set = hit_i && dsrv_set_bit_i;
        strb_o.dsrv_clr = hit_i && dsrv_clr_bit_i && !dsrv_set_bit_i;
        strb_o.tick_set = hit_i && tick_set_bit_i;
        strb_o.tick_clr = hit_i && tick_clr_bit_i && !tick_set_bit_i;
    end

endmodule

// File: rtl/icsr_trig_check.sv
module icsr_trig_check
    import icsr_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic             hit_i,
    input  logic [VEC_W-1:0] id_i,
    output logic             fire_o,
    output logic [VEC_W-1:0] id_o
);

    logic in_range;

    assign in_range = int'(id_i) < NUM_IRQ;
    assign fire_o   = hit_i && in_range;
    assign id_o     = fire_o ? id_i : '0;

endmodule

// File: rtl/icsr_ctrl.sv
module icsr_ctrl
    import icsr_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [11:0]        addr_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    input  logic               act_valid_i,
    input  logic [8:0]         act_vec_i,
    input  logic               pend_valid_i,
    input  logic [8:0]         pend_vec_i,
    input  logic [NUM_IRQ-1:0] irq_pend_i,
    input  logic [NUM_IRQ-1:0] irq_act_i,
    input  logic               nmi_pend_i,
    input  logic               dsrv_pend_i,
    input  logic               tick_pend_i,
    output logic               nmi_set_o,
    output logic               dsrv_set_o,
    output logic               dsrv_clr_o,
    output logic               tick_set_o,
    output logic               tick_clr_o,
    output logic               ext_trig_o,
    output logic [8:0]         ext_trig_id_o
);

    localparam int BANKS = NUM_IRQ / 32;
    localparam logic [DATA_W-1:0] TYPE_VAL = DATA_W'(BANKS - 1);

    logic [DATA_W-1:0] stat_word;
    sys_strb_t         sys_strb;
    logic              trig_fire;
    logic [VEC_W-1:0]  trig_id;
    logic              stat_hit, trig_hit;
    logic              unused_wdata;
    regs_t             regs_d, regs_q;

    assign stat_hit     = wr_en_i && (addr_i == OFS_STAT);
    assign trig_hit     = wr_en_i && (addr_i == OFS_TRIG);
    assign unused_wdata = ^{wdata_i[30:29], wdata_i[24:9]};

    icsr_status #(.NUM_IRQ(NUM_IRQ)) i_status (
        .act_valid_i  (act_valid_i),
        .act_vec_i    (act_vec_i),
        .pend_valid_i (pend_valid_i),
        .pend_vec_i   (pend_vec_i),
        .irq_pend_i   (irq_pend_i),
        .irq_act_i    (irq_act_i),
        .nmi_pend_i   (nmi_pend_i),
        .dsrv_pend_i  (dsrv_pend_i),
        .tick_pend_i  (tick_pend_i),
        .word_o       (stat_word)
    );

    icsr_wr_decode i_decode (
        .hit_i          (stat_hit),
        .nmi_bit_i      (wdata_i[B_NMI_SET]),
        .dsrv_set_bit_i (wdata_i[B_DSRV_SET]),
        .dsrv_clr_bit_i (wdata_i[B_DSRV_CLR]),
        .tick_set_bit_i (wdata_i[B_TICK_SET]),
        .tick_clr_bit_i (wdata_i[B_TICK_CLR]),
        .strb_o         (sys_strb)
    );

    icsr_trig_check #(.NUM_IRQ(NUM_IRQ)) i_trig (
        .hit_i  (trig_hit),
        .id_i   (wdata_i[VEC_W-1:0]),
        .fire_o (trig_fire),
        .id_o   (trig_id)
    );

    always_comb begin
        regs_d         = regs_q;
        regs_d.sys     = sys_strb;
        regs_d.trig    = trig_fire;
        regs_d.trig_id = trig_id;
        if (rd_en_i) begin
            unique case (addr_i)
                OFS_TYPE: regs_d.rdata = TYPE_VAL;
                OFS_STAT: regs_d.rdata = stat_word;
                default:  regs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata_o       = regs_q.rdata;
    assign nmi_set_o     = regs_q.sys.nmi_set;
    assign dsrv_set_o    = regs_q.sys.dsrv_set;
    assign dsrv_clr_o    = regs_q.sys.dsrv_clr;
    assign tick_set_o    = regs_q.sys.tick_set;
    assign tick_clr_o    = regs_q.sys.tick_clr;
    assign ext_trig_o    = regs_q.trig;
    assign ext_trig_id_o = regs_q.trig_id;

    // R6
    a_r6_nmi_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == OFS_STAT && wdata_i[31]) |=> nmi_set_o);

    // R7
    a_r7_dsrv_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == OFS_STAT && wdata_i[28]) |=> (dsrv_set_o && !dsrv_clr_o));

    a_r7_tick_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == OFS_STAT && wdata_i[26]) |=> (tick_set_o && !tick_clr_o));

    // R8
    a_r8_trig_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == OFS_TRIG && int'(wdata_i[8:0]) >= NUM_IRQ) |=> !ext_trig_o);

    // R11
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> !(nmi_set_o || dsrv_set_o || dsrv_clr_o || tick_set_o || tick_clr_o || ext_trig_o));

    // R10
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));

endmodule

// File: tb/test_icsr_ctrl.sv
module test_icsr_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NIRQ = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            act_valid = 1'b0, pend_valid = 1'b0;
    logic [8:0]      act_vec = '0, pend_vec = '0;
    logic [NIRQ-1:0] irq_pend = '0, irq_act = '0;
    logic            nmi_p = 1'b0, dsrv_p = 1'b0, tick_p = 1'b0;
    logic            nmi_set, dsrv_set, dsrv_clr, tick_set, tick_clr, ext_trig;
    logic [8:0]      ext_id;

    int vectors = 0;
    int errors  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icsr_ctrl #(.NUM_IRQ(NIRQ)) i_icsr_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .act_valid_i(act_valid), .act_vec_i(act_vec),
        .pend_valid_i(pend_valid), .pend_vec_i(pend_vec),
        .irq_pend_i(irq_pend), .irq_act_i(irq_act),
        .nmi_pend_i(nmi_p), .dsrv_pend_i(dsrv_p), .tick_pend_i(tick_p),
        .nmi_set_o(nmi_set), .dsrv_set_o(dsrv_set), .dsrv_clr_o(dsrv_clr),
        .tick_set_o(tick_set), .tick_clr_o(tick_clr),
        .ext_trig_o(ext_trig), .ext_trig_id_o(ext_id)
    );

    // strobe vector: {nmi_set, dsrv_set, dsrv_clr, tick_set, tick_clr, ext_trig}
    function automatic logic [5:0] strobes();
        return {nmi_set, dsrv_set, dsrv_clr, tick_set, tick_clr, ext_trig};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // write; returns the strobe vector seen in the following cycle
    task automatic bus_write(logic [11:0] a, logic [31:0] d, output logic [5:0] s, output logic [8:0] id);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        s = strobes();
        id = ext_id;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset();
        check("R1 strobes", 32'(strobes()), 32'h0);
        check("R1 rdata", rdata, 32'h0);
    endtask

    task automatic t_vec_fields();
        logic [31:0] d;
        act_valid = 1'b1; act_vec = 9'd35; pend_valid = 1'b1; pend_vec = 9'd19;
        bus_read(12'hD04, d);
        check("R2 both valid", d, (32'd19 << 12) | 32'd35);
        act_valid = 1'b0; pend_vec = 9'h1FF;
        bus_read(12'hD04, d);
        check("R2 active invalid", d, 32'h1FF << 12);
        act_valid = 1'b1; act_vec = 9'd3; pend_valid = 1'b0;
        bus_read(12'hD04, d);
        check("R2 pending invalid", d, 32'd3);
        act_valid = 1'b0;
    endtask

    task automatic t_any_pend();
        logic [31:0] d;
        irq_pend = '0; irq_pend[NIRQ-1] = 1'b1;
        bus_read(12'hD04, d);
        check("R3 top line pending", d, 32'h1 << 22);
        irq_pend = '0;
        bus_read(12'hD04, d);
        check("R3 none pending", d, 32'h0);
    endtask

    task automatic t_other_act();
        logic [31:0] d;
        act_valid = 1'b1; act_vec = 9'd19; irq_act = '0; irq_act[3] = 1'b1;
        bus_read(12'hD04, d);
        check("R4 only current active", d, 32'd19);
        irq_act[7] = 1'b1;
        bus_read(12'hD04, d);
        check("R4 another active", d, 32'd19 | (32'h1 << 11));
        act_valid = 1'b0; irq_act = '0; irq_act[3] = 1'b1;
        bus_read(12'hD04, d);
        check("R4 none in service", d, 32'h1 << 11);
        irq_act = '0;
    endtask

    task automatic t_sys_pend();
        logic [31:0] d;
        nmi_p = 1'b1; dsrv_p = 1'b1; tick_p = 1'b1;
        bus_read(12'hD04, d);
        check("R5 all three", d, 32'h9400_0000);
        nmi_p = 1'b0; tick_p = 1'b0;
        bus_read(12'hD04, d);
        check("R5 deferred only", d, 32'h1000_0000);
        dsrv_p = 1'b0;
    endtask

    task automatic t_set_strobes();
        logic [5:0] s; logic [8:0] id;
        bus_write(12'hD04, 32'h8000_0000, s, id);
        check("R6 nmi set", 32'(s), 32'b100000);
        bus_write(12'hD04, 32'h1000_0000, s, id);
        check("R6 deferred set", 32'(s), 32'b010000);
        bus_write(12'hD04, 32'h0400_0000, s, id);
        check("R6 tick set", 32'(s), 32'b000100);
        @(negedge clk);
        check("R11 one-cycle pulse", 32'(strobes()), 32'h0);
    endtask

    task automatic t_collision();
        logic [5:0] s; logic [8:0] id;
        bus_write(12'hD04, 32'h0800_0000, s, id);
        check("R7 deferred clear alone", 32'(s), 32'b001000);
        bus_write(12'hD04, 32'h0200_0000, s, id);
        check("R7 tick clear alone", 32'(s), 32'b000010);
        bus_write(12'hD04, 32'h1800_0000, s, id);
        check("R7 deferred set beats clear", 32'(s), 32'b010000);
        bus_write(12'hD04, 32'h0600_0000, s, id);
        check("R7 tick set beats clear", 32'(s), 32'b000100);
        bus_write(12'hD04, 32'h0C00_0000, s, id);
        check("R7 mixed tick set and deferred clear", 32'(s), 32'b001100);
        bus_write(12'hD04, 32'h9E00_0000, s, id);
        check("R7 everything", 32'(s), 32'b110100);
    endtask

    task automatic t_trigger();
        logic [5:0] s; logic [8:0] id;
        bus_write(12'hF00, 32'd63, s, id);
        check("R8 last legal strobe", 32'(s), 32'b000001);
        check("R8 last legal id", 32'(id), 32'd63);
        bus_write(12'hF00, 32'hABCD_E205, s, id);
        check("R8 upper bits ignored id", 32'(id), 32'd5);
        bus_write(12'hF00, 32'd64, s, id);
        check("R8 count rejected", 32'(s), 32'h0);
        bus_write(12'hF00, 32'h1FF, s, id);
        check("R8 max rejected", 32'(s), 32'h0);
    endtask

    task automatic t_other_offsets();
        logic [31:0] d; logic [5:0] s; logic [8:0] id;
        bus_read(12'h004, d);
        check("R9 type register", d, 32'(NIRQ/32 - 1));
        nmi_p = 1'b1;
        bus_read(12'hD08, d);
        check("R9 unknown offset", d, 32'h0);
        nmi_p = 1'b0;
        bus_write(12'hD08, 32'hFFFF_FFFF, s, id);
        check("R11 write elsewhere", 32'(s), 32'h0);
        bus_write(12'h004, 32'hFFFF_FFFF, s, id);
        check("R11 write to type", 32'(s), 32'h0);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        dsrv_p = 1'b1;
        bus_read(12'hD04, d);
        check("R10 read value", d, 32'h1000_0000);
        dsrv_p = 1'b0; tick_p = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 held without read", rdata, 32'h1000_0000);
        tick_p = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_vec_fields();
        t_any_pend();
        t_other_act();
        t_sys_pend();
        t_set_strobes();
        t_collision();
        t_trigger();
        t_other_offsets();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule